// File: doc/BRIEF.md
# Priority Vector Arbiter

This block picks which interrupt source a processor should service next, for a controller with 64 sources. Each source has a pending bit, an enable bit, a type bit (normal or fast) and a 4-bit priority. The priorities arrive packed into 32-bit words, eight sources to a word. Normal sources compete on priority. Fast sources are served in index order. Both results are presented as 32-bit vector words. A reserved all-ones value means that nothing is waiting.

Reading a vector word is also the acknowledge for that source. The bus logic that sits around this block raises a read-enable for the normal or the fast vector. The block answers with a one-cycle clear mask that names the source it reported. The owner of the pending register uses that mask to drop the bit. A read-enable held high over several cycles still clears only once.

Top module: `pva_arbiter`

## Requirements
- R1: The priority of source n is read from bits 32*(n/8) + 4*(n mod 8) + 3 down to 32*(n/8) + 4*(n mod 8) of `prioWords`.
- R2: A source takes part in normal arbitration only when its pending bit is 1, its enable bit is 1 and its type bit is 0. A source with type bit 1 is fast.
- R3: The normal winner is the participating source with the largest priority value.
- R4: When several participating sources share the largest priority, the one with the highest source number wins.
- R5: `normVector` carries the winner's number in bits 31:16 and its priority in bits 3:0, with zeros elsewhere. Priority 0 is a valid winner.
- R6: With no participating normal source, `normVector` is 0xFFFFFFFF and a normal read clears nothing.
- R7: `fastVector` holds the lowest-numbered source that is pending, enabled and of type 1, zero-extended to 32 bits.
- R8: With no such fast source, `fastVector` is 0xFFFFFFFF and a fast read clears nothing.
- R9: On the first clock edge where a read-enable is seen high after being low, `clrMask` shows the one-hot bit of the source reported at that edge during the next cycle. Normal and fast clears taken at the same edge are ORed together.
- R10: A read-enable held high over several edges gives exactly one clear. `clrMask` is zero in every other cycle.
- R11: While `rstN` is low, `clrMask` is zero. A read-enable found high at the first edge after reset counts as a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendingVec | input | 64 | Pending bit per source |
| enableVec | input | 64 | Enable bit per source |
| fastTypeVec | input | 64 | Type per source, 1 = fast |
| prioWords | input | 256 | Packed 4-bit priorities, eight per 32-bit word |
| normRdEn | input | 1 | Read-enable of the normal vector word |
| fastRdEn | input | 1 | Read-enable of the fast vector word |
| normVector | output | 32 | Normal vector word |
| fastVector | output | 32 | Fast vector word |
| clrMask | output | 64 | One-cycle clear request per source |

## Verification
The assertions assume that the pending, enable, type and priority inputs stay steady from the edge that accepts a read until the clear mask appears. Without that, the one-hot clear bit could name a source that is no longer active. The stimulus changes these vectors only at falling edges and only while both read-enables are low. It then holds them through each read sequence. The read-enables are driven as clean levels, so the one-shot properties see every rise and hold that the bus could produce.

// File: rtl/pva_pkg.sv
package pva_pkg;
  localparam int DEF_NUM_SRC = 64;
  localparam int DEF_PRIO_W  = 4;
  localparam int VEC_W       = 32;
  localparam logic [VEC_W-1:0] EMPTY_VEC = '1;

  typedef struct packed {
    logic normTake;
    logic fastTake;
  } ackStrobe_t;
endpackage

// File: rtl/pva_control.sv
module pva_control
  import pva_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       normRdEn,
  input  logic       fastRdEn,
  output ackStrobe_t strobe
);
  logic normRdQ;
  logic fastRdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      normRdQ <= 1'b0;
      fastRdQ <= 1'b0;
    end else begin
      normRdQ <= normRdEn;
      fastRdQ <= fastRdEn;
    end
  end

  // Accept only the first cycle of a read, so a stalled bus clears once.
  always_comb begin
    strobe.normTake = normRdEn & ~normRdQ;
    strobe.fastTake = fastRdEn & ~fastRdQ;
  end

  AST_NORM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.normTake |=> !strobe.normTake); // R10
  AST_FAST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fastTake |=> !strobe.fastTake); // R10
endmodule

// File: rtl/pva_datapath.sv
module pva_datapath
  import pva_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int PRIO_W  = DEF_PRIO_W,
  localparam int PER_WORD = VEC_W / PRIO_W,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int PRIO_BITS = NUM_SRC * PRIO_W
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   pendingVec,
  input  logic [NUM_SRC-1:0]   enableVec,
  input  logic [NUM_SRC-1:0]   fastTypeVec,
  input  logic [PRIO_BITS-1:0] prioWords,
  input  ackStrobe_t           strobe,
  output logic [VEC_W-1:0]     normVector,
  output logic [VEC_W-1:0]     fastVector,
  output logic [NUM_SRC-1:0]   clrMask
);
  logic [PRIO_W-1:0]  srcPrio [NUM_SRC];
  logic [NUM_SRC-1:0] normActive;
  logic [NUM_SRC-1:0] fastActive;
  logic               normFound;
  logic [IDX_W-1:0]   normIdx;
  logic [PRIO_W-1:0]  normPrio;
  logic               fastFound;
  logic [IDX_W-1:0]   fastIdx;
  logic [NUM_SRC-1:0] normClr;
  logic [NUM_SRC-1:0] fastClr;

  // Priority unpacking: word g/PER_WORD, nibble g%PER_WORD.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign srcPrio[g] = prioWords[(g / PER_WORD) * VEC_W + (g % PER_WORD) * PRIO_W +: PRIO_W];
  end

  assign normActive = pendingVec & enableVec & ~fastTypeVec;
  assign fastActive = pendingVec & enableVec &  fastTypeVec;

  // Ascending scan with >=: later (higher) indices win ties, priority 0 counts.
  always_comb begin
    normFound = 1'b0;
    normIdx   = '0;
    normPrio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (normActive[i] && (!normFound || srcPrio[i] >= normPrio)) begin
        normFound = 1'b1;
        normIdx   = IDX_W'(i);
        normPrio  = srcPrio[i];
      end
    end
  end

  // Descending scan: the last hit is the lowest index.
  always_comb begin
    fastFound = 1'b0;
    fastIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (fastActive[i]) begin
        fastFound = 1'b1;
        fastIdx   = IDX_W'(i);
      end
    end
  end

  assign normVector = normFound
    ? {{(VEC_W/2 - IDX_W){1'b0}}, normIdx, {(VEC_W/2 - PRIO_W){1'b0}}, normPrio}
    : EMPTY_VEC;
  assign fastVector = fastFound ? {{(VEC_W - IDX_W){1'b0}}, fastIdx} : EMPTY_VEC;

  always_comb begin
    normClr = '0;
    fastClr = '0;
    if (strobe.normTake && normFound) normClr[normIdx] = 1'b1;
    if (strobe.fastTake && fastFound) fastClr[fastIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) clrMask <= '0;
    else       clrMask <= normClr | fastClr;
  end

  AST_NORM_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (normVector == EMPTY_VEC) |-> (normActive == '0)); // R6
  AST_NORM_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (normVector != EMPTY_VEC) |-> normActive[normVector[VEC_W/2 +: IDX_W]]); // R2
  AST_FAST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (fastVector != EMPTY_VEC) |-> fastActive[fastVector[IDX_W-1:0]]); // R7
  AST_CLR_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (clrMask != '0) |-> $past(strobe.normTake || strobe.fastTake)); // R9
  AST_CLR_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $countones(clrMask) <= 2); // R9
endmodule

// File: rtl/pva_arbiter.sv
module pva_arbiter
  import pva_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int PRIO_W  = DEF_PRIO_W
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          pendingVec,
  input  logic [NUM_SRC-1:0]          enableVec,
  input  logic [NUM_SRC-1:0]          fastTypeVec,
  input  logic [NUM_SRC*PRIO_W-1:0]   prioWords,
  input  logic                        normRdEn,
  input  logic                        fastRdEn,
  output logic [VEC_W-1:0]            normVector,
  output logic [VEC_W-1:0]            fastVector,
  output logic [NUM_SRC-1:0]          clrMask
);
  ackStrobe_t strobe;

  pva_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .normRdEn (normRdEn),
    .fastRdEn (fastRdEn),
    .strobe   (strobe)
  );

  pva_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .pendingVec  (pendingVec),
    .enableVec   (enableVec),
    .fastTypeVec (fastTypeVec),
    .prioWords   (prioWords),
    .strobe      (strobe),
    .normVector  (normVector),
    .fastVector  (fastVector),
    .clrMask     (clrMask)
  );

  AST_RESET_NO_CLEAR: assert property (@(posedge clk)
    $past(!rstN) |-> (clrMask == '0)); // R11
endmodule

// File: tb/pva_arbiter_tb.sv
module pva_arbiter_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [63:0]  pendingVec = '0;
  logic [63:0]  enableVec = '0;
  logic [63:0]  fastTypeVec = '0;
  logic [255:0] prioWords = '0;
  logic         normRdEn = 1'b0;
  logic         fastRdEn = 1'b0;
  logic [31:0]  normVector;
  logic [31:0]  fastVector;
  logic [63:0]  clrMask;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pva_arbiter u_dut (
    .clk(clk), .rstN(rstN), .pendingVec(pendingVec), .enableVec(enableVec),
    .fastTypeVec(fastTypeVec), .prioWords(prioWords), .normRdEn(normRdEn),
    .fastRdEn(fastRdEn), .normVector(normVector), .fastVector(fastVector),
    .clrMask(clrMask)
  );

  typedef struct packed {
    logic [63:0] pend;
    logic [63:0] en;
    logic [63:0] typ;
    logic [1:0]  cfg;
  } stim_t;

  localparam int NUM_ROWS = 6;
  localparam stim_t TABLE [NUM_ROWS] = '{
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0},
    '{64'h0000_0000_0000_F0F0, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0000_0000_00F0, 2'd0},
    '{64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd1},
    '{64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0000_00FF_0000, 2'd0},
    '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0},
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 64'h0, 2'd1}
  };

  function automatic logic [255:0] makeCfg(int c);
    logic [255:0] w = '0;
    for (int n = 0; n < 64; n++) begin
      logic [3:0] p;
      p = (c == 0) ? 4'((n * 7) % 16) : (c == 1) ? 4'd3 : 4'd0;
      w[(n / 8) * 32 + (n % 8) * 4 +: 4] = p;
    end
    return w;
  endfunction

  // Reference: descending scan, strictly greater, so the highest index keeps a tie.
  function automatic logic [31:0] refNorm(logic [63:0] p, logic [63:0] e, logic [63:0] t,
                                          logic [255:0] pw);
    int best = -1;
    int idx = -1;
    for (int n = 63; n >= 0; n--) begin
      if (p[n] && e[n] && !t[n]) begin
        int pr;
        pr = int'(pw[(n / 8) * 32 + (n % 8) * 4 +: 4]);
        if (pr > best) begin best = pr; idx = n; end
      end
    end
    if (idx < 0) return 32'hFFFF_FFFF;
    return (32'(idx) << 16) | 32'(best);
  endfunction

  function automatic logic [31:0] refFast(logic [63:0] p, logic [63:0] e, logic [63:0] t);
    for (int n = 0; n < 64; n++)
      if (p[n] && e[n] && t[n]) return 32'(n);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset holds the clear mask at zero even with a read raised
    @(negedge clk);
    prioWords = makeCfg(1);
    pendingVec = 64'h1; enableVec = '1; normRdEn = 1'b1;
    tick(); tick();
    check("R11 reset clear", clrMask, 64'h0);
    normRdEn = 1'b0;
    tick();
    rstN = 1'b1;
    tick();

    // Table sweep (R2, R3, R4, R7)
    for (int r = 0; r < NUM_ROWS; r++) begin
      pendingVec = TABLE[r].pend; enableVec = TABLE[r].en;
      fastTypeVec = TABLE[r].typ; prioWords = makeCfg(int'(TABLE[r].cfg));
      tick();
      check("R3 table normal", 64'(normVector),
            64'(refNorm(pendingVec, enableVec, fastTypeVec, prioWords)));
      check("R7 table fast", 64'(fastVector), 64'(refFast(pendingVec, enableVec, fastTypeVec)));
    end

    // R5: lone priority-0 source is reported
    prioWords = makeCfg(2); pendingVec = 64'h400; enableVec = '1; fastTypeVec = '0;
    tick();
    check("R5 prio0 lone", 64'(normVector), 64'h000A_0000);

    // R4: tie at priority 3 goes to source 40
    prioWords = makeCfg(1);
    pendingVec = (64'h1 << 3) | (64'h1 << 40) | (64'h1 << 20);
    tick();
    check("R4 tie highest", 64'(normVector), 64'h0028_0003);

    // R1: only source 19's nibble is set
    prioWords = '0; prioWords[2 * 32 + 12 +: 4] = 4'h9;
    pendingVec = (64'h1 << 19) | (64'h1 << 20);
    tick();
    check("R1 unpack", 64'(normVector), 64'h0013_0009);

    // R2: a disabled source and a fast source do not compete
    prioWords = makeCfg(0);
    pendingVec = (64'h1 << 9) | (64'h1 << 2) | (64'h1 << 5);
    enableVec = ~(64'h1 << 9); fastTypeVec = 64'h1 << 5;
    tick();
    check("R2 filter", 64'(normVector), 64'h0002_000E);
    check("R7 fast only", 64'(fastVector), 64'd5);

    // R9/R10: simultaneous reads held for two edges
    prioWords = makeCfg(1);
    pendingVec = (64'h1 << 3) | (64'h1 << 40) | (64'h1 << 12);
    enableVec = '1; fastTypeVec = 64'h1 << 12;
    tick();
    check("R9 idle mask", clrMask, 64'h0);
    normRdEn = 1'b1; fastRdEn = 1'b1;
    tick();
    check("R9 both clear", clrMask, (64'h1 << 40) | (64'h1 << 12));
    tick();
    check("R10 held read", clrMask, 64'h0);
    normRdEn = 1'b0; fastRdEn = 1'b0;
    tick();
    fastRdEn = 1'b1;
    tick();
    check("R9 fast clear", clrMask, 64'h1 << 12);
    fastRdEn = 1'b0;
    tick();

    // R6/R8: empty reads
    pendingVec = '0;
    tick();
    check("R6 empty normal", 64'(normVector), 64'hFFFF_FFFF);
    check("R8 empty fast", 64'(fastVector), 64'hFFFF_FFFF);
    normRdEn = 1'b1; fastRdEn = 1'b1;
    tick();
    check("R6 R8 no clear", clrMask, 64'h0);
    normRdEn = 1'b0; fastRdEn = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule